// File: doc/BRIEF.md
# Programmable Trigger Logic Unit

This block turns up to six asynchronous trigger inputs into one global trigger, which is sent to up to four devices under test. A deserializer upstream delivers each input as a 16-sample vector on every system clock. The block scans every vector for a rising edge and notes where in the clock period that edge falls. It then looks up the set of active inputs in a 64-entry truth table that software loads. This lets the trigger condition be any Boolean function of the six inputs.

Busy lines from the devices can hold off new triggers. A per-device mask chooses which busy lines take part, and a mode bit turns the gating off altogether. Each accepted trigger produces a one-cycle record. The record holds:
- a 48-bit coarse timestamp from a free-running clock counter,
- the mask of active inputs,
- a 4-bit sub-clock arrival time for each input,
- a sequence number.

A second counter keeps the number of triggers that the busy gating suppressed.

Top module: `trig_logic_unit`

## Requirements
- R1: A synchronous reset clears the coarse stamp counter, the sequence counter, the vetoed-trigger counter, the record valid flag and all trigger outputs. The first trigger after reset therefore carries stamp 0 and sequence 0.
- R2: Each input `i` occupies bits `[16*i+15:16*i]` of `samp_in`, and sample 0 is the earliest. An input is active in a cycle when any sample is 1 while the sample before it is 0. For sample 0, the sample before it is the last sample of the previous cycle, which is taken as 0 after reset. A vector that stays high from the previous cycle is not active.
- R3: The fine time of an active input is the index (0 to 15) of its first rising sample. The record places input `i`'s fine time in `rec_fine[4*i+3:4*i]`. The field is 0 for an input that is not active.
- R4: When `in_enable[i]` is 0, input `i` is treated as inactive. Its mask bit is 0, its fine time is 0, and it plays no part in the decision.
- R5: The active mask, with bit `i` for input `i`, forms an index into `truth_table`. A trigger is wanted when the addressed bit is 1. This includes index 0, when no input is active.
- R6: An accepted trigger raises `rec_valid` and every bit of `trig_out` together, for exactly one clock. This happens in the cycle after the samples that caused it. Accepted triggers in consecutive cycles give consecutive pulses.
- R7: The coarse stamp counter advances by one on every clock after reset. `rec_stamp` holds the value the counter had during the cycle of the triggering samples.
- R8: When `veto_on` is 1 and any busy line whose `busy_enable` bit is 1 is high in the same cycle, a wanted trigger is not issued. Instead, `veto_count` rises by one, and it is visible one cycle later.
- R9: A busy line whose enable bit is 0 never blocks a trigger. With `veto_on` at 0, no busy line blocks a trigger.
- R10: `rec_seq` holds the number of accepted triggers before this one. Vetoed and unwanted cycles do not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_in | input | 96 | Sixteen oversampled bits per input, input i at [16i+15:16i] |
| in_enable | input | 6 | Per-input participation mask |
| truth_table | input | 64 | Trigger function, indexed by the active mask |
| busy_in | input | 4 | Busy lines from the devices |
| busy_enable | input | 4 | Selects the busy lines that may block |
| veto_on | input | 1 | Turns busy gating on |
| trig_out | output | 4 | Global trigger to each device |
| rec_valid | output | 1 | Record valid for one cycle per accepted trigger |
| rec_stamp | output | 48 | Coarse timestamp of the trigger |
| rec_mask | output | 6 | Active inputs that formed the decision |
| rec_fine | output | 24 | Fine arrival time per input, 4 bits each |
| rec_seq | output | 32 | Sequence number of the trigger |
| veto_count | output | 32 | Number of wanted triggers suppressed by busy |

## Verification
The trigger, the record and `veto_count` all change on the clock edge that closes the cycle in which the samples and busy levels were presented. The record stamp is the count of clocks from the release of reset to that cycle. The driver presents one sample set at each falling edge and pushes the expected result for that cycle. The monitor pops it 2 ns after the following rising edge, so each comparison falls exactly one register stage after its stimulus. The bench drives every cycle after reset, so its own cycle count gives the expected stamp.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  localparam int unsigned DEF_INPUTS  = 6;
  localparam int unsigned DEF_DUTS    = 4;
  localparam int unsigned DEF_SPC     = 16;
  localparam int unsigned DEF_STAMP_W = 48;
  localparam int unsigned DEF_CNT_W   = 32;

  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_FIRE = 2'd1,
    DEC_VETO = 2'd2
  } decision_e;

  // Busy gating only bites when the mode is on and a selected line is high.
  function automatic logic busy_blocks(input logic mode_on, input logic any_busy);
    return mode_on & any_busy;
  endfunction

endpackage

// File: rtl/tlu_edge_lane.sv
module tlu_edge_lane #(
  parameter int unsigned SPC    = 16,
  parameter int unsigned FINE_W = $clog2(SPC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPC-1:0]    samples,
  input  logic              lane_en,
  output logic              active,
  output logic [FINE_W-1:0] fine
);

  logic              prev_q;
  logic [FINE_W:0]   hit;

  // Returns {found, index of lowest sample that rises from the one before it}.
  function automatic logic [FINE_W:0] first_rise(input logic [SPC-1:0] s, input logic p);
    logic [SPC-1:0]  rises;
    logic [FINE_W:0] r;
    rises = s & ~{s[SPC-2:0], p};
    r = '0;
    for (int i = SPC - 1; i >= 0; i--) begin
      if (rises[i]) r = {1'b1, FINE_W'(i)};
    end
    return r;
  endfunction

  always_comb begin
    hit    = first_rise(samples, prev_q);
    active = lane_en & hit[FINE_W];
    fine   = active ? hit[FINE_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= samples[SPC-1];
  end

endmodule

// File: rtl/tlu_decide.sv
module tlu_decide
  import tlu_pkg::*;
#(
  parameter int unsigned N_IN  = 6,
  parameter int unsigned N_DUT = 4,
  parameter int unsigned TT_W  = 1 << N_IN
) (
  input  logic [N_IN-1:0]  act_mask,
  input  logic [TT_W-1:0]  truth_table,
  input  logic [N_DUT-1:0] busy_in,
  input  logic [N_DUT-1:0] busy_enable,
  input  logic             veto_on,
  output logic             tt_hit,
  output logic             veto_hit,
  output decision_e        decision
);

  always_comb begin
    tt_hit   = truth_table[act_mask];
    veto_hit = busy_blocks(veto_on, |(busy_in & busy_enable));
    if (!tt_hit)      decision = DEC_IDLE;
    else if (veto_hit) decision = DEC_VETO;
    else              decision = DEC_FIRE;
  end

endmodule

// File: rtl/tlu_record.sv
module tlu_record
  import tlu_pkg::*;
#(
  parameter int unsigned N_IN    = 6,
  parameter int unsigned N_DUT   = 4,
  parameter int unsigned FINE_W  = 4,
  parameter int unsigned STAMP_W = 48,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  decision_e              decision,
  input  logic [N_IN-1:0]        act_mask,
  input  logic [N_IN*FINE_W-1:0] fine_bus,
  output logic [STAMP_W-1:0]     stamp_now,
  output logic [N_DUT-1:0]       trig_out,
  output logic                   rec_valid,
  output logic [STAMP_W-1:0]     rec_stamp,
  output logic [N_IN-1:0]        rec_mask,
  output logic [N_IN*FINE_W-1:0] rec_fine,
  output logic [CNT_W-1:0]       rec_seq,
  output logic [CNT_W-1:0]       veto_count
);

  logic [STAMP_W-1:0] stamp_q;
  logic [CNT_W-1:0]   seq_q;
  logic [CNT_W-1:0]   veto_q;
  logic               fire;

  assign fire = (decision == DEC_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q   <= '0;
      seq_q     <= '0;
      veto_q    <= '0;
      rec_valid <= 1'b0;
      rec_stamp <= '0;
      rec_mask  <= '0;
      rec_fine  <= '0;
      rec_seq   <= '0;
    end else begin
      stamp_q   <= stamp_q + 1'b1;
      rec_valid <= fire;
      if (fire) begin
        rec_stamp <= stamp_q;
        rec_mask  <= act_mask;
        rec_fine  <= fine_bus;
        rec_seq   <= seq_q;
        seq_q     <= seq_q + 1'b1;
      end
      if (decision == DEC_VETO) veto_q <= veto_q + 1'b1;
    end
  end

  // One flop per device output so each line can be placed near its connector.
  for (genvar d = 0; d < N_DUT; d++) begin : g_dut
    logic trig_q;
    always_ff @(posedge clk) begin
      if (rst) trig_q <= 1'b0;
      else     trig_q <= fire;
    end
    assign trig_out[d] = trig_q;
  end

  assign stamp_now  = stamp_q;
  assign veto_count = veto_q;

endmodule

// File: rtl/trig_logic_unit.sv
module trig_logic_unit
  import tlu_pkg::*;
#(
  parameter int unsigned N_IN    = DEF_INPUTS,
  parameter int unsigned N_DUT   = DEF_DUTS,
  parameter int unsigned SPC     = DEF_SPC,
  parameter int unsigned STAMP_W = DEF_STAMP_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned FINE_W  = $clog2(SPC),
  parameter int unsigned TT_W    = 1 << N_IN
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN*SPC-1:0]    samp_in,
  input  logic [N_IN-1:0]        in_enable,
  input  logic [TT_W-1:0]        truth_table,
  input  logic [N_DUT-1:0]       busy_in,
  input  logic [N_DUT-1:0]       busy_enable,
  input  logic                   veto_on,
  output logic [N_DUT-1:0]       trig_out,
  output logic                   rec_valid,
  output logic [STAMP_W-1:0]     rec_stamp,
  output logic [N_IN-1:0]        rec_mask,
  output logic [N_IN*FINE_W-1:0] rec_fine,
  output logic [CNT_W-1:0]       rec_seq,
  output logic [CNT_W-1:0]       veto_count
);

  // Internal events, named so the bound checker can see them.
  logic [N_IN-1:0]        lane_act;
  logic [N_IN*FINE_W-1:0] fine_bus;
  logic                   tt_hit;
  logic                   veto_hit;
  decision_e              decision;
  logic [STAMP_W-1:0]     stamp_now;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    tlu_edge_lane #(
      .SPC    (SPC),
      .FINE_W (FINE_W)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .samples (samp_in[i*SPC +: SPC]),
      .lane_en (in_enable[i]),
      .active  (lane_act[i]),
      .fine    (fine_bus[i*FINE_W +: FINE_W])
    );
  end

  tlu_decide #(
    .N_IN  (N_IN),
    .N_DUT (N_DUT),
    .TT_W  (TT_W)
  ) u_decide (
    .act_mask    (lane_act),
    .truth_table (truth_table),
    .busy_in     (busy_in),
    .busy_enable (busy_enable),
    .veto_on     (veto_on),
    .tt_hit      (tt_hit),
    .veto_hit    (veto_hit),
    .decision    (decision)
  );

  tlu_record #(
    .N_IN    (N_IN),
    .N_DUT   (N_DUT),
    .FINE_W  (FINE_W),
    .STAMP_W (STAMP_W),
    .CNT_W   (CNT_W)
  ) u_record (
    .clk        (clk),
    .rst        (rst),
    .decision   (decision),
    .act_mask   (lane_act),
    .fine_bus   (fine_bus),
    .stamp_now  (stamp_now),
    .trig_out   (trig_out),
    .rec_valid  (rec_valid),
    .rec_stamp  (rec_stamp),
    .rec_mask   (rec_mask),
    .rec_fine   (rec_fine),
    .rec_seq    (rec_seq),
    .veto_count (veto_count)
  );

endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int unsigned N_IN    = 6,
  parameter int unsigned N_DUT   = 4,
  parameter int unsigned STAMP_W = 48,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [N_IN-1:0]    in_enable,
  input logic [N_DUT-1:0]   busy_in,
  input logic [N_DUT-1:0]   busy_enable,
  input logic               veto_on,
  input logic               tt_hit,
  input logic               veto_hit,
  input logic [STAMP_W-1:0] stamp_now,
  input logic [N_DUT-1:0]   trig_out,
  input logic               rec_valid,
  input logic [STAMP_W-1:0] rec_stamp,
  input logic [N_IN-1:0]    rec_mask,
  input logic [CNT_W-1:0]   rec_seq,
  input logic [CNT_W-1:0]   veto_count
);

  AST_TRIG_WITH_RECORD: assert property (@(posedge clk) disable iff (rst)
    trig_out == {N_DUT{rec_valid}});                                             // R6

  AST_FIRE_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (rst)
    (tt_hit && !veto_hit) |=> rec_valid);                                        // R5

  AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (veto_on && |(busy_in & busy_enable)) |=> !rec_valid);                       // R8

  AST_NO_GATE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!veto_on && tt_hit) |=> rec_valid);                                         // R9

  AST_MASK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ((rec_mask & ~$past(in_enable)) == '0));                       // R4

  AST_STAMP_RUNS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stamp_now == $past(stamp_now) + 1'b1));                     // R7

  AST_STAMP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_stamp == $past(stamp_now)));                              // R7

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && $past(rec_valid)) |-> (rec_seq == $past(rec_seq) + 1'b1));     // R10

  AST_VETO_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((veto_count == $past(veto_count)) ||
                     (veto_count == $past(veto_count) + 1'b1)));                 // R8

endmodule

bind trig_logic_unit tlu_checker #(
  .N_IN    (N_IN),
  .N_DUT   (N_DUT),
  .STAMP_W (STAMP_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_enable   (in_enable),
  .busy_in     (busy_in),
  .busy_enable (busy_enable),
  .veto_on     (veto_on),
  .tt_hit      (tt_hit),
  .veto_hit    (veto_hit),
  .stamp_now   (stamp_now),
  .trig_out    (trig_out),
  .rec_valid   (rec_valid),
  .rec_stamp   (rec_stamp),
  .rec_mask    (rec_mask),
  .rec_seq     (rec_seq),
  .veto_count  (veto_count)
);

// File: tb/trig_logic_unit_tb.sv
module trig_logic_unit_tb;

  localparam int NI  = 6;
  localparam int ND  = 4;
  localparam int SPC = 16;
  localparam int FW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NI*SPC-1:0] samp;
  logic [NI-1:0]     in_en;
  logic [63:0]       tt;
  logic [ND-1:0]     busy;
  logic [ND-1:0]     busy_en;
  logic              veto_on;

  logic [ND-1:0]     trig_out;
  logic              rec_valid;
  logic [47:0]       rec_stamp;
  logic [NI-1:0]     rec_mask;
  logic [NI*FW-1:0]  rec_fine;
  logic [31:0]       rec_seq;
  logic [31:0]       veto_count;

  trig_logic_unit u_dut (
    .clk         (clk),
    .rst         (rst),
    .samp_in     (samp),
    .in_enable   (in_en),
    .truth_table (tt),
    .busy_in     (busy),
    .busy_enable (busy_en),
    .veto_on     (veto_on),
    .trig_out    (trig_out),
    .rec_valid   (rec_valid),
    .rec_stamp   (rec_stamp),
    .rec_mask    (rec_mask),
    .rec_fine    (rec_fine),
    .rec_seq     (rec_seq),
    .veto_count  (veto_count)
  );

  typedef struct packed {
    logic             valid;
    logic [47:0]      stamp;
    logic [NI-1:0]    mask;
    logic [NI*FW-1:0] fine;
    logic [31:0]      seq;
    logic [31:0]      vcnt;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // Reference state kept from the requirements.
  logic [NI-1:0] m_prev;
  logic [47:0]   m_cyc;
  logic [31:0]   m_seq;
  logic [31:0]   m_veto;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NI*SPC-1:0] pk6(input logic [15:0] a0, a1, a2, a3, a4, a5);
    return {a5, a4, a3, a2, a1, a0};
  endfunction

  // Driver: presents one cycle of samples and queues the result it must give.
  task automatic drive(input logic [NI*SPC-1:0] s);
    exp_t             e;
    logic [NI-1:0]    act;
    logic [NI*FW-1:0] f;
    logic             want, blk;
    samp = s;
    act  = '0;
    f    = '0;
    for (int i = 0; i < NI; i++) begin
      logic p;
      bit   found;
      p     = m_prev[i];
      found = 1'b0;
      for (int k = 0; k < SPC; k++) begin
        if (!found && s[i*SPC+k] && !p) begin
          found = 1'b1;
          if (in_en[i]) begin
            act[i]        = 1'b1;
            f[i*FW +: FW] = FW'(k);
          end
        end
        p = s[i*SPC+k];
      end
      m_prev[i] = s[i*SPC+SPC-1];
    end
    want    = tt[act];
    blk     = veto_on && (|(busy & busy_en));
    e.valid = want && !blk;
    e.stamp = m_cyc;
    e.mask  = act;
    e.fine  = f;
    e.seq   = m_seq;
    if (e.valid) m_seq = m_seq + 1;
    if (want && blk) m_veto = m_veto + 1;
    e.vcnt  = m_veto;
    q.push_back(e);
    m_cyc = m_cyc + 1;
    @(negedge clk);
  endtask

  // Monitor: compares each result one register stage after its stimulus.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(rec_valid == e.valid, "R6", "rec_valid", 64'(rec_valid), 64'(e.valid));
        check(trig_out == {ND{e.valid}}, "R6", "trig_out", 64'(trig_out), 64'({ND{e.valid}}));
        check(veto_count == e.vcnt, "R8", "veto_count", 64'(veto_count), 64'(e.vcnt));
        if (e.valid) begin
          check(rec_stamp == e.stamp, "R7", "rec_stamp", 64'(rec_stamp), 64'(e.stamp));
          check(rec_mask == e.mask, "R2", "rec_mask", 64'(rec_mask), 64'(e.mask));
          check(rec_fine == e.fine, "R3", "rec_fine", 64'(rec_fine), 64'(e.fine));
          check(rec_seq == e.seq, "R10", "rec_seq", 64'(rec_seq), 64'(e.seq));
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    samp    = '0;
    in_en   = '1;
    tt      = 64'h2;
    busy    = '0;
    busy_en = '1;
    veto_on = 1'b1;
    m_prev  = '0;
    m_cyc   = '0;
    m_seq   = '0;
    m_veto  = '0;
    repeat (3) @(negedge clk);
    // R1: state after reset
    check(rec_valid == 1'b0, "R1", "rec_valid after reset", 64'(rec_valid), 64'd0);
    check(trig_out == '0, "R1", "trig_out after reset", 64'(trig_out), 64'd0);
    check(veto_count == '0, "R1", "veto_count after reset", 64'(veto_count), 64'd0);
    rst = 1'b0;

    // R1 R3: first trigger carries stamp 0, seq 0, fine 5
    drive(pk6(16'hFFE0, 0, 0, 0, 0, 0));
    // R2: held-high vector is not an edge
    drive(pk6(16'hFFFF, 0, 0, 0, 0, 0));
    // R2 R3: low then rising at sample 8
    drive(pk6(16'hFF00, 0, 0, 0, 0, 0));
    // R2: sample 0 high after a high last sample, no edge
    drive(pk6(16'h0001, 0, 0, 0, 0, 0));
    // R2 R3: sample 0 rises from a low last sample
    drive(pk6(16'h0001, 0, 0, 0, 0, 0));
    drive(pk6(0, 0, 0, 0, 0, 0));
    // R5: AND of inputs 1 and 2 (index 6)
    tt = 64'h40;
    drive(pk6(0, 16'hFFF8, 16'hF000, 0, 0, 0));
    drive(pk6(0, 0, 0, 0, 0, 0));
    // R5: extra input gives index 7, not in the table
    drive(pk6(16'h0010, 16'h0100, 16'h8000, 0, 0, 0));
    // R4: input 2 disabled, index becomes 2, no trigger
    in_en = 6'b111011;
    drive(pk6(0, 16'h0002, 16'h0004, 0, 0, 0));
    in_en = '1;
    // R8: enabled busy line blocks and counts
    tt   = 64'h2;
    busy = 4'b0100;
    drive(pk6(16'h00F0, 0, 0, 0, 0, 0));
    drive(pk6(16'h0F00, 0, 0, 0, 0, 0));
    // R9: busy line masked off does not block
    busy_en = 4'b1011;
    drive(pk6(16'h0003, 0, 0, 0, 0, 0));
    // R9: gating mode off ignores all busy lines
    busy_en = '1;
    busy    = 4'hF;
    veto_on = 1'b0;
    drive(pk6(16'h0300, 0, 0, 0, 0, 0));
    veto_on = 1'b1;
    busy    = '0;
    // R5 R6: index 0 entry fires with no input, back to back
    tt = 64'h1;
    drive(pk6(0, 0, 0, 0, 0, 0));
    drive(pk6(0, 0, 0, 0, 0, 0));
    // R5: all six inputs, index 63
    tt = 64'h8000_0000_0000_0000;
    drive(pk6(16'h0040, 16'h0002, 16'h4000, 16'h0100, 16'h0008, 16'h1000));
    // Mixed traffic: R2 R3 R4 R8 R10
    tt = 64'hA5A5_0F0F_3C3C_9999;
    for (int k = 0; k < 60; k++) begin
      logic [NI*SPC-1:0] v;
      for (int i = 0; i < NI; i++) begin
        v[i*SPC +: SPC] = ((k + i) % 3 == 0) ? 16'h0 : (16'hFFFF << ((k * 3 + i * 5) % 16));
      end
      busy    = 4'(k % 7 == 0 ? 4'b0010 : 4'b0000);
      busy_en = (k % 14 == 0) ? 4'b1101 : 4'b1111;
      in_en   = (k % 5 == 0) ? 6'b101101 : 6'b111111;
      drive(v);
    end
    busy = '0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule